// File: doc/BRIEF.md
# Thermal Sensor Auto-Monitor Controller

This block runs a temperature-sensor converter without software help. Once automatic mode is on, a round timer starts a conversion round. In each round every sensor channel is converted in turn over a request/done handshake. The latest result for each channel is kept in a readable register, after an optional inversion that turns a falling code into a rising one. Each result is compared against two per-channel limits: an alarm limit and a shutdown limit.

A limit counts as crossed only after a programmable number of consecutive samples at or above it. A crossed alarm limit sets a pending bit, and the interrupt line reports it when the channel is unmasked. A crossed shutdown limit latches a hardware shutdown request. That request goes either to a reset/clock unit or to a pin whose active level is programmable. While any channel sits at or above its alarm limit, the round timer uses a shorter period so that a heating die is watched more closely.

Software reaches the block through a simple register port. A write takes effect at the clock edge where `reg_we` is high. A read is combinational on `reg_addr`.

Top module: `tsmon_ctrl`

## Requirements
- R1: After reset, the control word (0x04), the interrupt-enable word (0x08) and the pending word (0x0C) read 0. Both limits of every channel read 0x3FF. Both debounce counts (0x60 alarm, 0x64 shutdown) read 4. The normal period (0x50) reads 250 and the high-temperature period (0x54) reads 50. `conv_req`, `irq` and `shut_rcu` are low and `shut_pin` is high.
- R2: While control bit 0 is set, each round requests channels 0 up to NUM_CH-1 in that order. `conv_req` stays high with `conv_chan` stable until `conv_done`. The accepted code is stored and read back at 0x20 + 4×channel.
- R3: Between two rounds `conv_req` stays low for exactly the normal period in cycles (0x50). It uses the high-temperature period (0x54) instead while any channel's stored value is at or above its alarm limit.
- R4: With control bit 1 set, the stored value is (1024 − code) mod 1024. With the bit clear, it is the code itself.
- R5: A value is over a limit when it is greater than or equal to that limit. A limit of 0x3FF never triggers, for the alarm, the shutdown or the period choice.
- R6: Pending bit n sets on the sample that makes the run of consecutive over-alarm samples of channel n reach the count at 0x60. A count of 0 acts as 1. Any sample below the limit restarts the run.
- R7: Writing 1 to a bit of 0x0C clears that pending bit. A pending bit holds otherwise. `irq` is high exactly when some pending bit has its enable bit set in 0x08 (bit n for channel n).
- R8: Control bit 4+n arms shutdown for channel n against its limit at 0x40 + 4×n, with the run count at 0x64. Once tripped, the shutdown request stays set even when the values fall. It clears only on reset or when control bit 0 is cleared.
- R9: Control bit 12 picks the shutdown destination. When it is clear, a latched request drives `shut_rcu` high. When it is set, a latched request drives `shut_pin` to the active level. Control bit 8 set means `shut_pin` is active high; clear means active low. `shut_pin` sits at the inactive level otherwise.
- R10: Clearing control bit 0 drops `conv_req` and the shutdown request. No new request starts while the bit stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| conv_req | output | 1 | Conversion request to the sensor converter |
| conv_chan | output | CH_W | Channel being converted |
| conv_done | input | 1 | Converter result valid |
| conv_code | input | 10 | Raw converter code |
| irq | output | 1 | Alarm interrupt |
| shut_rcu | output | 1 | Shutdown request to the reset/clock unit, active high |
| shut_pin | output | 1 | Shutdown pin with programmable polarity |

## Verification
The bench builds the block with its defaults: two channels, 16-bit period words and 8-bit run counters. Both channels therefore exist, and the channel order within a round can be observed. The bench writes periods of 20 and 6 cycles at run time. This makes the gap between rounds short enough to count exactly. It also allows many samples in a short run, so debounce runs of 2 and 3, an interrupted run, and latched shutdown can all be driven by a converter model whose codes change between samples.

// File: rtl/tsmon_pkg.sv
package tsmon_pkg;

    localparam int CODE_W = 10;
    localparam logic [CODE_W-1:0] CODE_OFF = '1;

    // register byte offsets
    localparam logic [7:0] A_CTRL  = 8'h04;
    localparam logic [7:0] A_IRQEN = 8'h08;
    localparam logic [7:0] A_PEND  = 8'h0C;
    localparam logic [7:0] A_DATA  = 8'h20;
    localparam logic [7:0] A_ALRM  = 8'h30;
    localparam logic [7:0] A_SHUT  = 8'h40;
    localparam logic [7:0] A_PNORM = 8'h50;
    localparam logic [7:0] A_PHOT  = 8'h54;
    localparam logic [7:0] A_DALRM = 8'h60;
    localparam logic [7:0] A_DSHUT = 8'h64;

    // control word bit positions
    localparam int B_EN   = 0;
    localparam int B_INV  = 1;
    localparam int B_SHEN = 4;
    localparam int B_POL  = 8;
    localparam int B_DEST = 12;

    typedef struct packed {
        logic en;
        logic inv;
        logic pol_hi;
        logic dest_pin;
    } ctrl_t;

    typedef enum logic {
        S_WAIT = 1'b0,
        S_CONV = 1'b1
    } smp_state_e;

    // (1024 - q) mod 1024 is the two's complement of a 10-bit code
    function automatic logic [CODE_W-1:0] cond_code(input logic [CODE_W-1:0] q,
                                                   input logic inv);
        return inv ? (~q + 1'b1) : q;
    endfunction

    function automatic logic over_lim(input logic [CODE_W-1:0] v,
                                      input logic [CODE_W-1:0] lim);
        return (lim != CODE_OFF) && (v >= lim);
    endfunction

endpackage

// File: rtl/tsmon_sampler.sv
module tsmon_sampler
    import tsmon_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    parameter int PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              hot,
    input  logic [PER_W-1:0]  per_norm,
    input  logic [PER_W-1:0]  per_hot,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    output logic              smp_vld
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    smp_state_e        state_q;
    logic [PER_W-1:0]  timer_q;
    logic [CH_W-1:0]   chan_q;
    logic [PER_W-1:0]  limit;
    logic              fire;

    assign limit = hot ? per_hot : per_norm;
    // a period of 0 behaves as 1
    assign fire  = ({1'b0, timer_q} + 1'b1) >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= S_WAIT;
            timer_q <= '0;
            chan_q  <= '0;
        end else begin
            case (state_q)
                S_WAIT: begin
                    if (fire) begin
                        state_q <= S_CONV;
                        timer_q <= '0;
                        chan_q  <= '0;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                S_CONV: begin
                    if (conv_done) begin
                        if (chan_q == LAST_CH) begin
                            state_q <= S_WAIT;
                        end else begin
                            chan_q <= chan_q + 1'b1;
                        end
                    end
                end
                default: state_q <= S_WAIT;
            endcase
        end
    end

    assign conv_req  = (state_q == S_CONV) && en;
    assign conv_chan = chan_q;
    assign smp_vld   = conv_req && conv_done;

endmodule

// File: rtl/tsmon_chan.sv
module tsmon_chan
    import tsmon_pkg::*;
#(
    parameter int DEB_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] raw,
    input  logic              inv,
    input  logic [CODE_W-1:0] alm_lim,
    input  logic [CODE_W-1:0] sht_lim,
    input  logic              sht_arm,
    input  logic [DEB_W-1:0]  alm_deb,
    input  logic [DEB_W-1:0]  sht_deb,
    output logic [CODE_W-1:0] value,
    output logic              alm_hit,
    output logic              sht_hit,
    output logic              hot
);
    logic [CODE_W-1:0] val_now;
    logic [DEB_W-1:0]  alm_run_q, sht_run_q, alm_run_d, sht_run_d;
    logic              alm_over, sht_over;

    assign val_now  = cond_code(raw, inv);
    assign alm_over = over_lim(val_now, alm_lim);
    assign sht_over = sht_arm && over_lim(val_now, sht_lim);

    always_comb begin
        alm_run_d = '0;
        sht_run_d = '0;
        if (alm_over) alm_run_d = (alm_run_q == '1) ? alm_run_q : alm_run_q + 1'b1;
        if (sht_over) sht_run_d = (sht_run_q == '1) ? sht_run_q : sht_run_q + 1'b1;
    end

    assign alm_hit = smp_vld && alm_over && (alm_run_d >= alm_deb);
    assign sht_hit = smp_vld && sht_over && (sht_run_d >= sht_deb);

    always_ff @(posedge clk) begin
        if (rst) begin
            value     <= '0;
            alm_run_q <= '0;
            sht_run_q <= '0;
        end else if (smp_vld) begin
            value     <= val_now;
            alm_run_q <= alm_run_d;
            sht_run_q <= sht_run_d;
        end
    end

    assign hot = over_lim(value, alm_lim);

endmodule

// File: rtl/tsmon_ctrl.sv
module tsmon_ctrl
    import tsmon_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int PER_W    = 16,
    parameter int DEB_W    = 8,
    parameter int NORM_RST = 250,
    parameter int HOT_RST  = 50,
    parameter int DEB_RST  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_code,
    output logic              irq,
    output logic              shut_rcu,
    output logic              shut_pin
);
    ctrl_t              ctrl_q;
    logic [NUM_CH-1:0]  sht_arm_q, irq_en_q, pend_q;
    logic [CODE_W-1:0]  alm_lim_q [NUM_CH];
    logic [CODE_W-1:0]  sht_lim_q [NUM_CH];
    logic [CODE_W-1:0]  value     [NUM_CH];
    logic [PER_W-1:0]   per_norm_q, per_hot_q;
    logic [DEB_W-1:0]   alm_deb_q, sht_deb_q;
    logic [NUM_CH-1:0]  alm_hit, sht_hit, ch_hot;
    logic               smp_vld, shut_q, auto_en;
    logic               wdata_unused;

    assign auto_en      = ctrl_q.en;
    assign wdata_unused = ^reg_wdata[31:PER_W];

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            sht_arm_q  <= '0;
            irq_en_q   <= '0;
            per_norm_q <= PER_W'(NORM_RST);
            per_hot_q  <= PER_W'(HOT_RST);
            alm_deb_q  <= DEB_W'(DEB_RST);
            sht_deb_q  <= DEB_W'(DEB_RST);
            for (int i = 0; i < NUM_CH; i++) begin
                alm_lim_q[i] <= CODE_OFF;
                sht_lim_q[i] <= CODE_OFF;
            end
        end else if (reg_we) begin
            if (reg_addr == A_CTRL) begin
                ctrl_q.en       <= reg_wdata[B_EN];
                ctrl_q.inv      <= reg_wdata[B_INV];
                ctrl_q.pol_hi   <= reg_wdata[B_POL];
                ctrl_q.dest_pin <= reg_wdata[B_DEST];
                sht_arm_q       <= reg_wdata[B_SHEN +: NUM_CH];
            end
            if (reg_addr == A_IRQEN) irq_en_q   <= reg_wdata[NUM_CH-1:0];
            if (reg_addr == A_PNORM) per_norm_q <= reg_wdata[PER_W-1:0];
            if (reg_addr == A_PHOT)  per_hot_q  <= reg_wdata[PER_W-1:0];
            if (reg_addr == A_DALRM) alm_deb_q  <= reg_wdata[DEB_W-1:0];
            if (reg_addr == A_DSHUT) sht_deb_q  <= reg_wdata[DEB_W-1:0];
            for (int i = 0; i < NUM_CH; i++) begin
                if (reg_addr == A_ALRM + 8'(4 * i)) alm_lim_q[i] <= reg_wdata[CODE_W-1:0];
                if (reg_addr == A_SHUT + 8'(4 * i)) sht_lim_q[i] <= reg_wdata[CODE_W-1:0];
            end
        end
    end

    // pending bits: a new hit wins over a clearing write
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (alm_hit[i])
                    pend_q[i] <= 1'b1;
                else if (reg_we && reg_addr == A_PEND && reg_wdata[i])
                    pend_q[i] <= 1'b0;
            end
        end
    end

    // latched shutdown request
    always_ff @(posedge clk) begin
        if (rst || !ctrl_q.en) shut_q <= 1'b0;
        else if (|sht_hit)     shut_q <= 1'b1;
    end

    // register reads
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_EN]               = ctrl_q.en;
                reg_rdata[B_INV]              = ctrl_q.inv;
                reg_rdata[B_POL]              = ctrl_q.pol_hi;
                reg_rdata[B_DEST]             = ctrl_q.dest_pin;
                reg_rdata[B_SHEN +: NUM_CH]   = sht_arm_q;
            end
            A_IRQEN: reg_rdata[NUM_CH-1:0] = irq_en_q;
            A_PEND:  reg_rdata[NUM_CH-1:0] = pend_q;
            A_PNORM: reg_rdata[PER_W-1:0]  = per_norm_q;
            A_PHOT:  reg_rdata[PER_W-1:0]  = per_hot_q;
            A_DALRM: reg_rdata[DEB_W-1:0]  = alm_deb_q;
            A_DSHUT: reg_rdata[DEB_W-1:0]  = sht_deb_q;
            default: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (reg_addr == A_DATA + 8'(4 * i)) reg_rdata[CODE_W-1:0] = value[i];
                    if (reg_addr == A_ALRM + 8'(4 * i)) reg_rdata[CODE_W-1:0] = alm_lim_q[i];
                    if (reg_addr == A_SHUT + 8'(4 * i)) reg_rdata[CODE_W-1:0] = sht_lim_q[i];
                end
            end
        endcase
    end

    tsmon_sampler #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .PER_W  (PER_W)
    ) u_smp (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl_q.en),
        .hot       (|ch_hot),
        .per_norm  (per_norm_q),
        .per_hot   (per_hot_q),
        .conv_req  (conv_req),
        .conv_chan (conv_chan),
        .conv_done (conv_done),
        .smp_vld   (smp_vld)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tsmon_chan #(
            .DEB_W (DEB_W)
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .smp_vld (smp_vld && (conv_chan == CH_W'(g))),
            .raw     (conv_code),
            .inv     (ctrl_q.inv),
            .alm_lim (alm_lim_q[g]),
            .sht_lim (sht_lim_q[g]),
            .sht_arm (sht_arm_q[g]),
            .alm_deb (alm_deb_q),
            .sht_deb (sht_deb_q),
            .value   (value[g]),
            .alm_hit (alm_hit[g]),
            .sht_hit (sht_hit[g]),
            .hot     (ch_hot[g])
        );
    end

    assign irq      = |(pend_q & irq_en_q);
    assign shut_rcu = shut_q && !ctrl_q.dest_pin;
    assign shut_pin = (shut_q && ctrl_q.dest_pin) ? ctrl_q.pol_hi : !ctrl_q.pol_hi;

endmodule

// File: rtl/tsmon_ctrl_chk.sv
module tsmon_ctrl_chk #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              auto_en,
    input logic              conv_req,
    input logic              conv_done,
    input logic [CH_W-1:0]   conv_chan,
    input logic              shut_act,
    input logic              reg_we,
    input logic [7:0]        reg_addr,
    input logic              wdata0,
    input logic [NUM_CH-1:0] pend
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_done && auto_en) |=> (conv_req || !auto_en)); // R2

    AST_CHAN_STABLE: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_done) |=> ($stable(conv_chan) || !conv_req)); // R2

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> (!conv_req && !shut_act)); // R10

    AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (shut_act && auto_en) |=> (shut_act || !auto_en)); // R8

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend[0] && !(reg_we && reg_addr == 8'h0C && wdata0)) |=> pend[0]); // R7

endmodule

bind tsmon_ctrl tsmon_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .auto_en   (auto_en),
    .conv_req  (conv_req),
    .conv_done (conv_done),
    .conv_chan (conv_chan),
    .shut_act  (shut_q),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .wdata0    (reg_wdata[0]),
    .pend      (pend_q)
);

// File: tb/tsmon_ctrl_tb.sv
module tsmon_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        conv_req;
    logic [0:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_code = '0;
    logic        irq, shut_rcu, shut_pin;

    logic [9:0]  mdl [2];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done_flag = 0;

    always #4 clk = ~clk;

    tsmon_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .conv_req  (conv_req),
        .conv_chan (conv_chan),
        .conv_done (conv_done),
        .conv_code (conv_code),
        .irq       (irq),
        .shut_rcu  (shut_rcu),
        .shut_pin  (shut_pin)
    );

    // converter model: answers a request one cycle later, single-cycle done
    initial begin
        mdl[0] = 10'd100;
        mdl[1] = 10'd200;
        forever begin
            @(posedge clk);
            #2;
            if (conv_req && !conv_done) begin
                conv_done = 1'b1;
                conv_code = mdl[conv_chan];
            end else begin
                conv_done = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // returns at the negedge after the edge that accepted a sample of ch
    task automatic wait_sample(input int ch);
        do @(negedge clk); while (!(conv_done && conv_chan == 1'(ch)));
        @(negedge clk);
    endtask

    task automatic measure_gap(output int n);
        while (!conv_req) @(negedge clk);
        while (conv_req) @(negedge clk);
        n = 0;
        while (!conv_req) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 8'h04, 32'h0);
        rd_chk("R1 irq enable", 8'h08, 32'h0);
        rd_chk("R1 pending", 8'h0C, 32'h0);
        rd_chk("R1 alarm lim ch0", 8'h30, 32'h3FF);
        rd_chk("R1 shut lim ch1", 8'h44, 32'h3FF);
        rd_chk("R1 alarm deb", 8'h60, 32'd4);
        rd_chk("R1 shut deb", 8'h64, 32'd4);
        rd_chk("R1 norm period", 8'h50, 32'd250);
        rd_chk("R1 hot period", 8'h54, 32'd50);
        chk("R1 conv_req", 32'(conv_req), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 shut_rcu", 32'(shut_rcu), 32'h0);
        chk("R1 shut_pin", 32'(shut_pin), 32'h1);
    endtask

    task automatic t_sample;
        wr(8'h50, 32'd20);
        wr(8'h54, 32'd6);
        wr(8'h04, 32'h1);
        wait_sample(0);
        wait_sample(1);
        rd_chk("R2 data ch0", 8'h20, 32'd100);
        rd_chk("R2 data ch1", 8'h24, 32'd200);
    endtask

    task automatic t_invert;
        wr(8'h04, 32'h3);
        wait_sample(0);
        rd_chk("R4 inverted 100", 8'h20, 32'd924);
        mdl[0] = 10'd0;
        wait_sample(0);
        rd_chk("R4 inverted 0", 8'h20, 32'd0);
        wr(8'h04, 32'h1);
        mdl[0] = 10'd100;
        wait_sample(0);
        rd_chk("R4 plain 100", 8'h20, 32'd100);
    endtask

    task automatic t_period;
        int g;
        measure_gap(g);
        chk("R3 normal period gap", 32'(g), 32'd20);
        wr(8'h34, 32'd150);
        wait_sample(1);
        measure_gap(g);
        chk("R3 hot period gap", 32'(g), 32'd6);
        wr(8'h34, 32'h3FF);
        mdl[0] = 10'h3FF;
        wait_sample(0);
        wr(8'h0C, 32'h3);
        measure_gap(g);
        chk("R5 disabled limit keeps normal period", 32'(g), 32'd20);
        wait_sample(0);
        rd_chk("R5 disabled limit no pending", 8'h0C, 32'h0);
        mdl[0] = 10'd100;
        wait_sample(0);
    endtask

    task automatic t_alarm;
        wr(8'h60, 32'd3);
        wr(8'h08, 32'h1);
        wr(8'h30, 32'd150);
        wait_sample(0);
        wr(8'h0C, 32'h3);
        mdl[0] = 10'd200;
        wait_sample(0);
        wait_sample(0);
        rd_chk("R6 two samples no pending", 8'h0C, 32'h0);
        chk("R7 irq low", 32'(irq), 32'h0);
        wait_sample(0);
        rd_chk("R6 third sample pending", 8'h0C, 32'h1);
        chk("R7 irq high", 32'(irq), 32'h1);
        wr(8'h08, 32'h0);
        chk("R7 masked irq", 32'(irq), 32'h0);
        wr(8'h08, 32'h1);
        wr(8'h0C, 32'h1);
        rd_chk("R7 write one clears", 8'h0C, 32'h0);
        // broken run
        mdl[0] = 10'd100;
        wait_sample(0);
        wr(8'h0C, 32'h1);
        mdl[0] = 10'd150;
        wait_sample(0);
        wait_sample(0);
        mdl[0] = 10'd149;
        wait_sample(0);
        mdl[0] = 10'd150;
        wait_sample(0);
        wait_sample(0);
        rd_chk("R6 run restarted", 8'h0C, 32'h0);
        wait_sample(0);
        rd_chk("R5 equal to limit counts", 8'h0C, 32'h1);
        mdl[0] = 10'd100;
        wr(8'h30, 32'h3FF);
        wr(8'h08, 32'h0);
        wait_sample(0);
        wr(8'h0C, 32'h3);
    endtask

    task automatic t_shut;
        wr(8'h64, 32'd2);
        wr(8'h40, 32'd300);
        mdl[0] = 10'd400;
        wr(8'h04, 32'h1111);
        chk("R9 pin idle active-high", 32'(shut_pin), 32'h0);
        wait_sample(0);
        chk("R8 one sample no trip", 32'(shut_pin), 32'h0);
        wait_sample(0);
        chk("R9 pin driven high", 32'(shut_pin), 32'h1);
        chk("R9 rcu stays low", 32'(shut_rcu), 32'h0);
        mdl[0] = 10'd100;
        wait_sample(0);
        wait_sample(0);
        chk("R8 latched after cooling", 32'(shut_pin), 32'h1);
        wr(8'h04, 32'h1110);
        repeat (2) @(negedge clk);
        chk("R10 shutdown cleared", 32'(shut_pin), 32'h0);
        begin
            int seen = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (conv_req) seen++;
            end
            chk("R10 no requests while off", 32'(seen), 32'h0);
        end
        // reset/clock unit destination, active-low pin
        mdl[0] = 10'd400;
        wr(8'h04, 32'h0011);
        chk("R9 pin idle active-low", 32'(shut_pin), 32'h1);
        wait_sample(0);
        wait_sample(0);
        chk("R9 rcu driven", 32'(shut_rcu), 32'h1);
        chk("R9 pin stays idle", 32'(shut_pin), 32'h1);
        wr(8'h04, 32'h0);
        repeat (2) @(negedge clk);
        chk("R10 rcu cleared", 32'(shut_rcu), 32'h0);
        // shutdown not armed
        wr(8'h04, 32'h0001);
        wait_sample(0);
        wait_sample(0);
        wait_sample(0);
        chk("R8 unarmed channel no trip", 32'(shut_rcu), 32'h0);
        wr(8'h04, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sample();
        t_invert();
        t_period();
        t_alarm();
        t_shut();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule